// File: doc/BRIEF.md
# One-Shot Duration Timer

This block produces a single high interval of programmable length on its level output. A start strobe, given while the timer is idle, captures a parallel duration value into an internal down-counter. The level output stays high while that counter holds a nonzero value, and the counter steps down by one on every clock. When the counter reaches zero, it halts there and the level output drops.

A falling-edge detector follows the level output. It is built from two sampling flip-flops and issues a completion strobe one clock wide. That strobe can drive the start input of a second instance. Two instances wired in a ring, one timing the high phase and one timing the low phase, form a programmable periodic waveform. A duration of zero is a no-op. A start that arrives while the timer is counting is ignored.

Top module: `oneshot_timer`

## Requirements
- R1: When `start` is 1 and `level` is 0, the value on `duration` is captured, and if it is nonzero `level` is 1 from the next clock edge.
- R2: A captured duration D (D >= 1) keeps `level` at 1 for exactly D consecutive clock cycles, including the largest value 2^WIDTH-1.
- R3: `level` never rises unless `start` was 1 while `level` was 0 in the previous cycle.
- R4: The counter halts at zero with no wraparound: once `level` has fallen it stays 0 until the next accepted start.
- R5: A `start` strobe while `level` is 1 is ignored; the running interval keeps its original length.
- R6: `done` is 1 for exactly one cycle, beginning one clock after the first cycle in which `level` reads 0 following a high interval.
- R7: A captured duration of zero produces no high cycle on `level` and no `done` strobe.
- R8: A synchronous active-high `rst` held for one clock cycle clears the counter and the edge detector. After that clock edge, `level` and `done` are 0, and no `done` strobe follows from the aborted interval.
- R9: A start accepted in the first cycle after `level` falls launches a new interval at once, and the pending `done` of the finished interval is still issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Strobe that loads `duration` when idle |
| duration | input | WIDTH | Number of clock cycles the output stays high |
| level | output | 1 | High while the count is nonzero |
| done | output | 1 | One-cycle strobe after `level` falls |

## Verification
A corrupted count shows up at `level` as a high interval that is too long or too short. A counter that wraps shows up as a spurious second interval that begins on the cycle right after the fall. A fault in the edge detector's two flops shows up within two cycles of the fall, as a missing strobe, a strobe two cycles wide, or a strobe in the wrong cycle. Faults in the start gating appear as an interval stretched by a restart in mid-count, or as a rise on `level` when the duration is zero.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Two-stage history of the watched level: s1 is one cycle old, s2 two.
    typedef struct packed {
        logic s1;
        logic s2;
    } fall_pipe_t;

endpackage

// File: rtl/dwell_counter.sv
module dwell_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] duration,
    output logic             level
);

    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic       idle;

    assign idle = (state_q.cnt == ZERO);

    always_comb begin
        state_d = state_q;
        if (idle) begin
            if (start) begin
                state_d.cnt = duration;
            end
        end else begin
            state_d.cnt = state_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign level = !idle;

endmodule

// File: rtl/fall_detect.sv
module fall_detect
    import oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic pulse
);

    fall_pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.s1 = sig;
        pipe_d.s2 = pipe_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign pulse = pipe_q.s2 & ~pipe_q.s1;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] duration,
    output logic             level,
    output logic             done
);

    logic level_int;

    dwell_counter #(.WIDTH(WIDTH)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .duration (duration),
        .level    (level_int)
    );

    fall_detect edge_i (
        .clk   (clk),
        .rst   (rst),
        .sig   (level_int),
        .pulse (done)
    );

    assign level = level_int;

endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [WIDTH-1:0] duration,
    input logic             level,
    input logic             done
);

    // R1
    load_rises_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !level && duration != '0) |=> level);

    // R3
    no_spurious_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!level && !start) |=> !level);

    // R7
    zero_load_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !level && duration == '0) |=> !level);

    // R6
    done_one_wide_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(level, 2) && !$past(level)));

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!level && !done));

endmodule

bind oneshot_timer oneshot_timer_chk #(.WIDTH(WIDTH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .duration (duration),
    .level    (level),
    .done     (done)
);

// File: tb/oneshot_timer_tb.sv
module oneshot_timer_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] duration = '0;
    logic         level;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;

    // measurement results
    int hi_len, done_cnt, fall_at, done_at;

    oneshot_timer #(.WIDTH(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .duration (duration),
        .level    (level),
        .done     (done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe start for one cycle; returns at the negedge after the load edge.
    task automatic issue_start(input int d);
        @(negedge clk);
        start    = 1'b1;
        duration = W'(d);
        @(negedge clk);
        start    = 1'b0;
    endtask

    // Samples n negedges starting at the current one; optional start injection.
    task automatic measure(input int n, input int inj_at, input int inj_dur);
        hi_len = 0; done_cnt = 0; fall_at = -1; done_at = -1;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            start = 1'b0;
            if (level) hi_len++;
            else if (fall_at < 0 && hi_len > 0) fall_at = i;
            if (done) begin
                done_cnt++;
                if (done_at < 0) done_at = i;
            end
            if (i == inj_at) begin
                start    = 1'b1;
                duration = W'(inj_dur);
            end
        end
        start = 1'b0;
    endtask

    task automatic t_reset_state();
        check(level == 1'b0, "R8 level after reset", int'(level), 0);
        check(done == 1'b0, "R8 done after reset", int'(done), 0);
    endtask

    task automatic t_basic(input int d);
        issue_start(d);
        check(level == 1'b1, "R1 level high after load", int'(level), 1);
        measure(d + 12, -1, 0);
        check(hi_len == d, "R2 high length", hi_len, d);
        check(done_cnt == 1, "R6 done count", done_cnt, 1);
        check(done_at == fall_at + 1, "R6 done position", done_at, fall_at + 1);
    endtask

    task automatic t_no_wrap();
        issue_start(3);
        measure(30, -1, 0);
        check(hi_len == 3, "R4 no wraparound high count", hi_len, 3);
        check(level == 1'b0, "R4 level stays low", int'(level), 0);
        check(done_cnt == 1, "R4 single done", done_cnt, 1);
    endtask

    task automatic t_ignore_restart();
        issue_start(6);
        measure(20, 2, 9);
        check(hi_len == 6, "R5 restart ignored, high length", hi_len, 6);
        check(done_cnt == 1, "R5 done count", done_cnt, 1);
        measure(5, -1, 0);
        check(hi_len == 0, "R5 no deferred interval", hi_len, 0);
    endtask

    task automatic t_zero();
        issue_start(0);
        measure(10, -1, 0);
        check(hi_len == 0, "R7 zero load high cycles", hi_len, 0);
        check(done_cnt == 0, "R7 zero load done", done_cnt, 0);
    endtask

    task automatic t_back_to_back();
        int guard;
        issue_start(3);
        guard = 0;
        while (level && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        // first negedge with level low: done not yet high; request restart
        check(done == 1'b0, "R9 done not yet at fall", int'(done), 0);
        start    = 1'b1;
        duration = W'(4);
        @(negedge clk);
        start = 1'b0;
        check(level == 1'b1, "R9 relaunch immediate", int'(level), 1);
        check(done == 1'b1, "R9 pending done issued", int'(done), 1);
        measure(12, -1, 0);
        check(hi_len == 4, "R9 second interval length", hi_len, 4);
    endtask

    task automatic t_reset_abort();
        issue_start(10);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(level == 1'b0, "R8 level cleared mid-run", int'(level), 0);
        check(done == 1'b0, "R8 done cleared mid-run", int'(done), 0);
        measure(15, -1, 0);
        check(done_cnt == 0, "R8 no done after abort", done_cnt, 0);
        check(hi_len == 0, "R8 no high after abort", hi_len, 0);
    endtask

    task automatic t_no_start();
        measure(8, -1, 0);
        check(hi_len == 0, "R3 no rise without start", hi_len, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_no_start();
        t_basic(1);
        t_basic(2);
        t_basic(7);
        t_basic(255);
        t_no_wrap();
        t_ignore_restart();
        t_zero();
        t_back_to_back();
        t_reset_abort();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule